// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Control Register

This block is a watchdog timer. An 8-bit control register sets how long the timeout is, enables the window mode and holds a stop-in-background flag. Software writes the register over a plain register bus: one strobe, one data byte, and a read port that always shows the current value. There is no handshake and no back-pressure. A write is taken on the clock edge where the strobe is high.

The register has two sets of write rules. In normal mode the window-enable bit and the rate field may be written once after reset. In special mode they may be written any number of times. A mask bit carried in the same write byte cancels that write. On the edge where reset is released, the register takes its value from a preload port that stands in for non-volatile storage. If that value has a non-zero rate, the timeout starts running at once.

The timeout counter advances on tick enables from one of two clock sources. A select input chooses the oscillator tick, but only while the oscillator reports that it is good. If neither holds, the internal tick is used. In stop mode the counter halts, except in pseudo-stop with the oscillator selected and oscillator-in-stop enabled. When the timeout expires, the block raises a reset request for one cycle and then freezes until the next reset.

Top module: `wdog_ctl`

## Requirements
- R1: The read value is window enable at bit 7, stop-in-background flag at bit 6 and rate at bits 2:0. Bits 5, 4 and 3 always read 0.
- R2: While reset is asserted, the register takes bits 7, 6 and 2:0 of the preload input. A non-zero preloaded rate starts the timeout from zero when reset is released.
- R3: A write with bit 5 (mask) set leaves window enable and rate unchanged. In normal mode, the first unmasked write after reset locks window enable and rate until the next reset. A masked write does not lock them.
- R4: A written rate of 000 leaves the rate unchanged, and a written window enable of 0 leaves window enable unchanged, in both modes. In normal mode such a write still counts as the single allowed write.
- R5: In special mode, every unmasked write updates window enable and rate under the R4 rule, with no lock.
- R6: In normal mode the stop-in-background flag can only be set; writing 0 leaves it at 1. In special mode it takes the written bit. The mask does not apply to this flag.
- R7: With rate n from 1 to 7, the reset request rises after exactly 2^(BASE_EXP+2n) counted ticks since the last restart. A rate of 0 never raises it.
- R8: In normal mode, the timeout restarts on an accepted write with a non-zero rate, on an accepted write with window enable 1, and on a 0-to-1 change of the stop-in-background flag. A masked write that changes nothing does not restart it. In special mode, any write restarts it, masked or not.
- R9: The effective source is the oscillator tick when the select input and oscillator-good are both 1, and the internal tick otherwise. Ticks from the other source are ignored. Any change of the effective source restarts the timeout.
- R10: While stop is 1, ticks are not counted, unless pseudo-stop is 1, the oscillator is the effective source and oscillator-in-stop is enabled.
- R11: The reset request is high for exactly one cycle. After it, the counter holds and raises no further request until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the preload value |
| special_mode_i | input | 1 | 1 = special mode write rules, 0 = normal mode |
| preload_i | input | 8 | Reset-time register image from non-volatile storage |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data; bit 5 is the mask |
| rd_data_o | output | 8 | Current register value |
| irc_tick_i | input | 1 | Tick enable of the internal clock source |
| osc_tick_i | input | 1 | Tick enable of the oscillator clock source |
| osc_sel_i | input | 1 | Requests the oscillator source |
| osc_ok_i | input | 1 | Oscillator status good |
| stop_i | input | 1 | Stop mode active |
| pseudo_stop_i | input | 1 | Stop is a pseudo-stop |
| osc_stop_en_i | input | 1 | Oscillator keeps running in stop |
| reset_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The timeout is measured with dense ticks and with sparse random ticks. This shows whether the block counts tick enables or clock cycles. Both sources are driven with independent random ticks, so counting the wrong source gives a different expiry point. Counting is also run through stop, pseudo-stop and source changes. Masked, zero-valued and repeated writes are interleaved at random and compared against a bench model of the lock. This separates a write that changes nothing but still consumes the single allowed write from one that does not.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RATE_W   = 3;
  localparam int MAX_RATE = (1 << RATE_W) - 1;

  typedef struct packed {
    logic              win;
    logic              bgstop;
    logic              wmask;
    logic [1:0]        rsv;
    logic [RATE_W-1:0] rate;
  } wd_ctl_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_i,
  input  logic [7:0]        preload_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              restart_o
);
  logic              win_q, bg_q, locked_q;
  logic [RATE_W-1:0] rate_q;
  wd_ctl_t           wr_in;
  logic              accept;

  assign wr_in  = wd_ctl_t'(wr_data_i);
  assign accept = wr_en_i && !wr_in.wmask && (special_i || !locked_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= preload_i[7];
      bg_q     <= preload_i[6];
      rate_q   <= preload_i[RATE_W-1:0];
      locked_q <= 1'b0;
    end else begin
      if (accept) begin
        if (wr_in.rate != '0) rate_q <= wr_in.rate;
        if (wr_in.win)        win_q  <= 1'b1;
        if (!special_i)       locked_q <= 1'b1;
      end
      if (wr_en_i) begin
        if (special_i) bg_q <= wr_in.bgstop;
        else           bg_q <= bg_q | wr_in.bgstop;
      end
    end
  end

  always_comb begin
    restart_o = 1'b0;
    if (wr_en_i) begin
      if (special_i) restart_o = 1'b1;
      else if (accept && (wr_in.rate != '0 || wr_in.win)) restart_o = 1'b1;
      else if (!bg_q && wr_in.bgstop) restart_o = 1'b1;
    end
  end

  assign rd_data_o = {win_q, bg_q, 1'b0, 2'b00, rate_q};
  assign rate_o    = rate_q;

  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !special_i) |=> ($stable(rate_q) && $stable(win_q)));
  a_r3_mask_voids: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[5]) |=> ($stable(rate_q) && $stable(win_q)));
  a_r4_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[RATE_W-1:0] == '0) |=> $stable(rate_q));
  a_r6_bg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_q && !special_i) |=> bg_q);
endmodule

// File: rtl/wdog_clk_sel.sv
module wdog_clk_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic irc_tick_i,
  input  logic osc_tick_i,
  input  logic osc_sel_i,
  input  logic osc_ok_i,
  input  logic stop_i,
  input  logic pseudo_stop_i,
  input  logic osc_stop_en_i,
  output logic tick_o,
  output logic sel_chg_o
);
  logic eff_sel, eff_q, run;

  assign eff_sel = osc_sel_i && osc_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= eff_sel;
    else        eff_q <= eff_sel;
  end

  assign sel_chg_o = eff_sel != eff_q;
  assign run       = !stop_i || (pseudo_stop_i && eff_sel && osc_stop_en_i);
  assign tick_o    = run && (eff_sel ? osc_tick_i : irc_tick_i);

  a_r9_src_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_q && eff_sel && !osc_tick_i) |-> !tick_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              tick_i,
  input  logic              restart_i,
  output logic [BASE_EXP+2*MAX_RATE-1:0] count_o,
  output logic              req_o
);
  localparam int CW = BASE_EXP + 2 * MAX_RATE;

  logic [CW-1:0] count_q, term;
  logic          expired_q, req_q;

  assign term = {CW{1'b1}} >> (2 * (MAX_RATE - int'(rate_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      expired_q <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!expired_q) begin
        if (restart_i) begin
          count_q <= '0;
        end else if (tick_i && rate_i != '0) begin
          if (count_q == term) begin
            expired_q <= 1'b1;
            req_q     <= 1'b1;
          end else begin
            count_q <= count_q + CW'(1);
          end
        end
      end
    end
  end

  assign count_o = count_q;
  assign req_o   = req_q;

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q |=> ($stable(count_q) && !req_q));
  a_r7_rate_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0) |=> !req_q);
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode_i,
  input  logic [7:0] preload_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       irc_tick_i,
  input  logic       osc_tick_i,
  input  logic       osc_sel_i,
  input  logic       osc_ok_i,
  input  logic       stop_i,
  input  logic       pseudo_stop_i,
  input  logic       osc_stop_en_i,
  output logic       reset_req_o
);
  localparam int CW = BASE_EXP + 2 * MAX_RATE;

  logic [RATE_W-1:0] rate_w;
  logic              reg_restart, sel_chg, tick_w, restart_w;
  logic [CW-1:0]     cnt_w;

  wdog_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .special_i(special_mode_i), .preload_i(preload_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .rate_o(rate_w), .restart_o(reg_restart)
  );

  wdog_clk_sel u_sel (
    .clk(clk), .rst_n(rst_n), .irc_tick_i(irc_tick_i), .osc_tick_i(osc_tick_i),
    .osc_sel_i(osc_sel_i), .osc_ok_i(osc_ok_i), .stop_i(stop_i),
    .pseudo_stop_i(pseudo_stop_i), .osc_stop_en_i(osc_stop_en_i),
    .tick_o(tick_w), .sel_chg_o(sel_chg)
  );

  assign restart_w = reg_restart || sel_chg;

  wdog_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rate_i(rate_w), .tick_i(tick_w),
    .restart_i(restart_w), .count_o(cnt_w), .req_o(reset_req_o)
  );

  a_r10_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !pseudo_stop_i && !restart_w) |=> $stable(cnt_w));
  a_r9_sel_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> ((cnt_w == '0) || $stable(cnt_w)));
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (rd_data_o[5:3] == 3'b000));
endmodule

// File: tb/sim_wdog_ctl.sv
module sim_wdog_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_EXP   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic special = 1'b0;
  logic [7:0] preload = 8'h00;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irc_tick = 1'b0, osc_tick = 1'b0;
  logic osc_sel = 1'b0, osc_ok = 1'b0;
  logic stop = 1'b0, pstop = 1'b0, osc_en = 1'b0;
  logic reset_req;

  int checks = 0, failures = 0, cyc = 0;
  int tick_cnt = 0, req_cnt = 0, req_at = -1;
  logic [7:0] m_reg;
  logic       m_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_ctl #(.BASE_EXP(BASE_EXP)) u0 (
    .clk(clk), .rst_n(rst_n), .special_mode_i(special), .preload_i(preload),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .irc_tick_i(irc_tick), .osc_tick_i(osc_tick), .osc_sel_i(osc_sel),
    .osc_ok_i(osc_ok), .stop_i(stop), .pseudo_stop_i(pstop),
    .osc_stop_en_i(osc_en), .reset_req_o(reset_req)
  );

  function automatic int limit_of(input int rate);
    return 1 << (BASE_EXP + 2 * rate);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] pl, input logic spc);
    @(negedge clk);
    rst_n = 1'b0; preload = pl; special = spc;
    irc_tick = 1'b0; osc_tick = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_reg = pl & 8'hC7; m_lock = 1'b0;
    tick_cnt = 0; req_cnt = 0; req_at = -1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!d[5] && (special || !m_lock)) begin
      if (d[2:0] != 3'b000) m_reg[2:0] = d[2:0];
      if (d[7]) m_reg[7] = 1'b1;
      if (!special) m_lock = 1'b1;
    end
    if (special) m_reg[6] = d[6];
    else         m_reg[6] = m_reg[6] | d[6];
  endtask

  task automatic run_ticks(input int cycles, input int dens);
    for (int i = 0; i <= cycles; i++) begin
      @(negedge clk);
      if (reset_req) begin req_cnt++; req_at = tick_cnt; end
      if (i < cycles) begin
        irc_tick = ($urandom % 100) < dens;
        osc_tick = ($urandom % 100) < dens;
        if (!stop || (pstop && osc_sel && osc_ok && osc_en))
          tick_cnt += (osc_sel && osc_ok) ? int'(osc_tick) : int'(irc_tick);
      end else begin
        irc_tick = 1'b0; osc_tick = 1'b0;
      end
    end
  endtask

  task automatic set_src(input logic s, input logic ok);
    @(negedge clk);
    osc_sel = s; osc_ok = ok;
    @(negedge clk);
    tick_cnt = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));

    // R1 R2: preload image with reserved and mask bits set
    do_reset(8'hFF, 1'b0);
    chk("R1 R2 preload readback", int'(rd_data), 32'hC7);
    do_reset(8'h41, 1'b0);
    chk("R2 preload rate1", int'(rd_data), 32'h41);
    run_ticks(40, 100);
    chk("R7 R2 expiry dense rate1", req_at, limit_of(1));
    chk("R11 single request", req_cnt, 1);

    // R7: sparse random ticks, rate 2
    do_reset(8'h02, 1'b0);
    run_ticks(400, 40);
    chk("R7 expiry sparse rate2", req_at, limit_of(2));
    chk("R11 single request rate2", req_cnt, 1);

    // R7: rate 0 disabled
    do_reset(8'h00, 1'b0);
    run_ticks(200, 100);
    chk("R7 rate0 no request", req_cnt, 0);

    // R3 R4 R6 directed, normal mode
    do_reset(8'h00, 1'b0);
    wr(8'hA3);
    chk("R3 masked write voided", int'(rd_data), 0);
    wr(8'h00);
    chk("R4 zero write no change", int'(rd_data), 0);
    wr(8'h85);
    chk("R3 R4 lock consumed by zero write", int'(rd_data), 0);
    wr(8'h40);
    chk("R6 bg set", int'(rd_data), 32'h40);
    wr(8'h00);
    chk("R6 bg not cleared normal", int'(rd_data), 32'h40);

    // R3 R4 R6 random, normal mode
    do_reset(8'h00, 1'b0);
    for (int i = 0; i < 30; i++) begin
      wr(8'($urandom));
      chk("R3 R4 R6 random normal", int'(rd_data), int'(m_reg));
    end

    // R5 R6 random, special mode
    do_reset(8'h00, 1'b1);
    for (int i = 0; i < 30; i++) begin
      wr(8'($urandom));
      chk("R5 R6 random special", int'(rd_data), int'(m_reg));
    end

    // R8: masked write without bg change does not restart
    do_reset(8'h01, 1'b0);
    run_ticks(10, 100);
    wr(8'h27);
    run_ticks(30, 100);
    chk("R8 masked normal no restart", req_at, limit_of(1));

    // R8: bg rise restarts
    do_reset(8'h01, 1'b0);
    run_ticks(10, 100);
    wr(8'h40);
    tick_cnt = 0;
    run_ticks(30, 100);
    chk("R8 bg rise restart", req_at, limit_of(1));

    // R8: accepted non-zero rate write restarts
    do_reset(8'h01, 1'b0);
    run_ticks(10, 100);
    wr(8'h01);
    tick_cnt = 0;
    run_ticks(30, 100);
    chk("R8 rate write restart", req_at, limit_of(1));

    // R8: special mode, masked write still restarts
    do_reset(8'h01, 1'b1);
    run_ticks(10, 100);
    wr(8'h27);
    chk("R3 special masked voided", int'(rd_data), 32'h01);
    tick_cnt = 0;
    run_ticks(30, 100);
    chk("R8 special any write restart", req_at, limit_of(1));

    // R9: change to oscillator source restarts and counts osc ticks
    osc_sel = 1'b0; osc_ok = 1'b1;
    do_reset(8'h01, 1'b0);
    run_ticks(8, 100);
    set_src(1'b1, 1'b1);
    run_ticks(80, 50);
    chk("R9 select change osc", req_at, limit_of(1));

    // R9: losing oscillator status restarts and falls back to internal
    do_reset(8'h01, 1'b0);
    run_ticks(8, 60);
    set_src(1'b1, 1'b0);
    run_ticks(80, 50);
    chk("R9 osc lost fallback", req_at, limit_of(1));

    // R10: full stop halts counting
    osc_sel = 1'b0; osc_ok = 1'b0;
    do_reset(8'h01, 1'b0);
    run_ticks(5, 100);
    @(negedge clk); stop = 1'b1;
    run_ticks(40, 100);
    chk("R10 halted in stop", req_cnt, 0);
    @(negedge clk); stop = 1'b0;
    run_ticks(30, 100);
    chk("R10 resumes after stop", req_at, limit_of(1));

    // R10: pseudo-stop with osc and enable keeps counting
    osc_sel = 1'b1; osc_ok = 1'b1; osc_en = 1'b1;
    do_reset(8'h01, 1'b0);
    @(negedge clk); stop = 1'b1; pstop = 1'b1;
    run_ticks(60, 70);
    chk("R10 pseudo-stop counts", req_at, limit_of(1));

    // R10: pseudo-stop without enable halts
    osc_en = 1'b0;
    do_reset(8'h01, 1'b0);
    run_ticks(60, 100);
    chk("R10 pseudo-stop no enable halts", req_cnt, 0);
    stop = 1'b0; pstop = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule